// File: doc/BRIEF.md
# DDR3 Power-Up and Reset Bring-Up Sequencer

This block is the controller-side state machine that takes a DDR3 SDRAM from an unknown state to ready for traffic. It drives the memory reset line, clock enable, on-die termination control, the command strobes, the bank address and the address bus. It has two entry paths. The cold path runs after a synchronous controller reset and waits for the supplies to be reported stable. The warm path is taken on a restart request, skips the supply wait and uses a much shorter reset hold.

After the reset and clock-enable waits, the sequencer writes the four mode registers in a fixed order (register 2, 3, 1, then 0) and then issues a long ZQ calibration. It then raises `init_done` once both the DLL lock time, counted from the register-0 write, and the calibration time, counted from the calibration command, have run out. The four mode-register payloads arrive as input words. Before issue, the block clears their reserved bits and forces the DLL-enable and DLL-reset bits. Every delay is a parameter given in controller clock cycles, and a single down-counter times them all.

There is no data stream at this block's edge. All pins are plain control or status levels, so there is no valid/ready handshake and no back-pressure.

Top module: `ddr3_bringup_seq`

## Requirements
- R1: While `rst_n` is sampled low and afterwards until `pwr_stable` is sampled high, the block drives `mem_reset_n`=0, `mem_cke`=0, `init_done`=0, a NOP on the bus (`mem_cs_n`=0, `mem_ras_n`=1, `mem_cas_n`=1, `mem_we_n`=1), `mem_ba`=0 and `mem_addr`=0.
- R2: On the cold path, `mem_reset_n` rises T_RST_COLD clock edges after the edge that first samples `pwr_stable` high.
- R3: A `warm_req` sampled high in any state drives `mem_reset_n`, `mem_cke` and `init_done` low from the next cycle. `mem_reset_n` then rises T_RST_WARM edges after the last edge that samples `warm_req` high, whatever the level of `pwr_stable`.
- R4: `mem_cke` is low whenever `mem_reset_n` is low. Every cycle that carries no mode-register write and no calibration drives a NOP with `mem_ba`=0 and `mem_addr`=0.
- R5: `mem_cke` rises T_CKE_WAIT edges after `mem_reset_n` rises. It then stays high until the next reset or warm request. `mem_odt` is always 0.
- R6: The first mode-register write (`mem_cs_n`, `mem_ras_n`, `mem_cas_n` and `mem_we_n` all 0, for one cycle) comes T_XPR cycles after `mem_cke` rises. The writes target `mem_ba` = 3'b010, 3'b011, 3'b001 and 3'b000 in that order, and consecutive writes are T_MRD cycles apart.
- R7: Each written address word is its input word with reserved bits cleared. The cleared bits are 13, 7 and 2 for register 0; 13, 10 and 8 for register 1; 13 to 11, 8 and 2 to 0 for register 2; and 13 to 3 for register 3. Bit 0 of the register-1 word is also forced to 0 (DLL enabled), and bit 8 of the register-0 word is forced to 1 (DLL reset).
- R8: T_MOD cycles after the register-0 write, the block issues one ZQ calibration cycle: `mem_cs_n`=0, `mem_ras_n`=1, `mem_cas_n`=1, `mem_we_n`=0, `mem_ba`=0, and `mem_addr` with only bit 10 set.
- R9: `init_done` rises max(T_MOD+T_ZQINIT, T_DLLK) cycles after the register-0 write. Only NOPs are driven in between, and `init_done` stays high until the next reset or warm request.
- R10: Sampling `rst_n` low part-way through a sequence returns the block to the cold path of R1, which again waits for `pwr_stable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low controller reset (cold restart) |
| pwr_stable | input | 1 | Supplies reported stable |
| warm_req | input | 1 | Warm restart request, short reset hold |
| mr0_word | input | ADDR_W | Payload for mode register 0 |
| mr1_word | input | ADDR_W | Payload for mode register 1 |
| mr2_word | input | ADDR_W | Payload for mode register 2 |
| mr3_word | input | ADDR_W | Payload for mode register 3 |
| mem_reset_n | output | 1 | Memory reset, active low |
| mem_cke | output | 1 | Memory clock enable |
| mem_odt | output | 1 | On-die termination control, held low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 3 | Bank address |
| mem_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Memory ready for normal commands |

## Verification
The assertions assume that `warm_req` and `rst_n` are the only ways a sequence is cut short. They also assume that the parameters give every wait at least one cycle and at least five cycles of clock-enable-low time. The ordering and spacing checks are reset by a warm request, so they hold across restarts at any point. The stimulus holds the payload words steady except while `rst_n` is low, so an address comparison never straddles a word change. It restarts the sequence at several points: during the supply wait, during the mode-register writes, and after ready.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [3:0] {
    S_PWR, S_RST, S_CKEW, S_XPR,
    S_MR2, S_MR3, S_MR1, S_MR0,
    S_ZQ, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
  localparam cmd_pins_t CMD_ZQL = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

  localparam logic [2:0] BA_NONE = 3'b111;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bringup_timer.sv
module bringup_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // A load always starts a fresh count; the counter never wraps below zero.
  assert_timer_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/mr_word_clean.sv
module mr_word_clean #(
  parameter int ADDR_W = 14
) (
  input  logic [3:0][ADDR_W-1:0] raw_words,
  output logic [3:0][ADDR_W-1:0] clean_words
);

  function automatic logic [ADDR_W-1:0] clear_mask(int idx);
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int b = 14; b < ADDR_W; b++) m[b] = 1'b1;
    case (idx)
      0: begin m[13] = 1'b1; m[7] = 1'b1; m[2] = 1'b1; end
      1: begin m[13] = 1'b1; m[10] = 1'b1; m[8] = 1'b1; m[0] = 1'b1; end
      2: begin m[13:11] = 3'b111; m[8] = 1'b1; m[2:0] = 3'b111; end
      default: m[13:3] = '1;
    endcase
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] force_mask(int idx);
    logic [ADDR_W-1:0] m;
    m = '0;
    if (idx == 0) m[8] = 1'b1;
    return m;
  endfunction

  for (genvar g = 0; g < 4; g++) begin : g_reg
    assign clean_words[g] = (raw_words[g] & ~clear_mask(g)) | force_mask(g);
  end

endmodule

// File: rtl/ddr3_bringup_seq.sv
module ddr3_bringup_seq
  import bringup_pkg::*;
#(
  parameter int ADDR_W              = 14,
  parameter int unsigned T_RST_COLD = 20,
  parameter int unsigned T_RST_WARM = 3,
  parameter int unsigned T_CKE_WAIT = 30,
  parameter int unsigned T_XPR      = 5,
  parameter int unsigned T_MRD      = 4,
  parameter int unsigned T_MOD      = 12,
  parameter int unsigned T_ZQINIT   = 16,
  parameter int unsigned T_DLLK     = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_stable,
  input  logic              warm_req,
  input  logic [ADDR_W-1:0] mr0_word,
  input  logic [ADDR_W-1:0] mr1_word,
  input  logic [ADDR_W-1:0] mr2_word,
  input  logic [ADDR_W-1:0] mr3_word,
  output logic              mem_reset_n,
  output logic              mem_cke,
  output logic              mem_odt,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [2:0]        mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  // Tail after calibration: DLL lock is counted from the MR0 write, so the
  // part already spent in the T_MOD gap is subtracted.
  localparam int unsigned DLL_TAIL = (T_DLLK > T_MOD) ? (T_DLLK - T_MOD) : 1;
  localparam int unsigned T_FINAL  = umax(T_ZQINIT, DLL_TAIL);
  localparam int unsigned LONGEST  = umax(umax(umax(T_RST_COLD, T_RST_WARM), umax(T_CKE_WAIT, T_XPR)),
                                          umax(umax(T_MRD, T_MOD), T_FINAL));
  localparam int CNT_W = $clog2(LONGEST + 1);
  localparam int GAP_W = CNT_W + 1;

  seq_state_e       st_q, st_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             expired;
  logic             first_q;
  logic [3:0][ADDR_W-1:0] clean;
  cmd_pins_t        cmd;

  bringup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .expired  (expired)
  );

  mr_word_clean #(.ADDR_W(ADDR_W)) u_clean (
    .raw_words   ({mr3_word, mr2_word, mr1_word, mr0_word}),
    .clean_words (clean)
  );

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    if (warm_req) begin
      st_d = S_RST; ld = 1'b1; ld_val = CNT_W'(T_RST_WARM - 1);
    end else begin
      case (st_q)
        S_PWR:  if (pwr_stable) begin st_d = S_RST;  ld = 1'b1; ld_val = CNT_W'(T_RST_COLD - 1); end
        S_RST:  if (expired)    begin st_d = S_CKEW; ld = 1'b1; ld_val = CNT_W'(T_CKE_WAIT - 1); end
        S_CKEW: if (expired)    begin st_d = S_XPR;  ld = 1'b1; ld_val = CNT_W'(T_XPR - 1);      end
        S_XPR:  if (expired)    begin st_d = S_MR2;  ld = 1'b1; ld_val = CNT_W'(T_MRD - 1);      end
        S_MR2:  if (expired)    begin st_d = S_MR3;  ld = 1'b1; ld_val = CNT_W'(T_MRD - 1);      end
        S_MR3:  if (expired)    begin st_d = S_MR1;  ld = 1'b1; ld_val = CNT_W'(T_MRD - 1);      end
        S_MR1:  if (expired)    begin st_d = S_MR0;  ld = 1'b1; ld_val = CNT_W'(T_MOD - 1);      end
        S_MR0:  if (expired)    begin st_d = S_ZQ;   ld = 1'b1; ld_val = CNT_W'(T_FINAL - 1);    end
        S_ZQ:   if (expired)    st_d = S_DONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_PWR;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= ld;
    end
  end

  // Pin decode
  always_comb begin
    cmd      = CMD_NOP;
    mem_ba   = 3'b000;
    mem_addr = '0;
    if (first_q) begin
      case (st_q)
        S_MR2: begin cmd = CMD_MRS; mem_ba = 3'b010; mem_addr = clean[2]; end
        S_MR3: begin cmd = CMD_MRS; mem_ba = 3'b011; mem_addr = clean[3]; end
        S_MR1: begin cmd = CMD_MRS; mem_ba = 3'b001; mem_addr = clean[1]; end
        S_MR0: begin cmd = CMD_MRS; mem_ba = 3'b000; mem_addr = clean[0]; end
        S_ZQ:  begin cmd = CMD_ZQL; mem_addr[10] = 1'b1; end
        default: ;
      endcase
    end
  end

  assign mem_cs_n    = cmd.cs_n;
  assign mem_ras_n   = cmd.ras_n;
  assign mem_cas_n   = cmd.cas_n;
  assign mem_we_n    = cmd.we_n;
  assign mem_reset_n = (st_q != S_PWR) && (st_q != S_RST);
  assign mem_cke     = (st_q != S_PWR) && (st_q != S_RST) && (st_q != S_CKEW);
  assign mem_odt     = 1'b0;
  assign init_done   = (st_q == S_DONE);

  // ---------------- checker state for ordering and spacing ----------------
  logic             is_mrs, is_zq;
  logic [2:0]       last_ba_q;
  logic [GAP_W-1:0] gap_q;

  assign is_mrs = !mem_cs_n && !mem_ras_n && !mem_cas_n && !mem_we_n;
  assign is_zq  = !mem_cs_n &&  mem_ras_n &&  mem_cas_n && !mem_we_n;

  always_ff @(posedge clk) begin
    if (!rst_n || warm_req) begin
      last_ba_q <= BA_NONE;
      gap_q     <= '0;
    end else begin
      if (is_mrs) last_ba_q <= mem_ba;
      if (is_mrs || is_zq)   gap_q <= GAP_W'(1);
      else if (gap_q != '1)  gap_q <= gap_q + 1'b1;
    end
  end

  assert_nop_while_cke_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> (!mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n));

  assert_cke_low_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_reset_n |-> !mem_cke);

  assert_cke_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_cke) && !$past(warm_req)) |-> mem_cke);

  assert_warm_drops_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    warm_req |=> (!mem_reset_n && !mem_cke && !init_done));

  assert_mr_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> ((mem_ba == 3'b010 && last_ba_q == BA_NONE) ||
                (mem_ba == 3'b011 && last_ba_q == 3'b010)  ||
                (mem_ba == 3'b001 && last_ba_q == 3'b011)  ||
                (mem_ba == 3'b000 && last_ba_q == 3'b001)));

  assert_mr_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && last_ba_q != BA_NONE) |-> (gap_q >= GAP_W'(T_MRD)));

  assert_zq_after_mr0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_zq |-> (last_ba_q == 3'b000 && mem_addr[10] && gap_q >= GAP_W'(T_MOD)));

  assert_ready_needs_cke_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (mem_cke && mem_reset_n && !is_mrs && !is_zq));

endmodule

// File: tb/tb_ddr3_bringup_seq.sv
module tb_ddr3_bringup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 14;
  localparam int TC    = 20;
  localparam int TW    = 3;
  localparam int TCKE  = 30;
  localparam int TXPR  = 5;
  localparam int TMRD  = 4;
  localparam int TMOD  = 12;
  localparam int TZQ   = 16;
  localparam int TDLLK = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_stable = 1'b0, warm_req = 1'b0;
  logic [AW-1:0] w0, w1, w2, w3;
  logic mem_reset_n, mem_cke, mem_odt, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, init_done;
  logic [2:0] mem_ba;
  logic [AW-1:0] mem_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr3_bringup_seq #(
    .ADDR_W(AW), .T_RST_COLD(TC), .T_RST_WARM(TW), .T_CKE_WAIT(TCKE), .T_XPR(TXPR),
    .T_MRD(TMRD), .T_MOD(TMOD), .T_ZQINIT(TZQ), .T_DLLK(TDLLK)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable), .warm_req(warm_req),
    .mr0_word(w0), .mr1_word(w1), .mr2_word(w2), .mr3_word(w3),
    .mem_reset_n(mem_reset_n), .mem_cke(mem_cke), .mem_odt(mem_odt),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_ba(mem_ba), .mem_addr(mem_addr), .init_done(init_done)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  string cold_tag = "R1";

  // Behavioural reference: mode 0 = waiting for supplies, mode 1 = timeline running.
  int mode = 0;
  int j = 0;
  bit warm_path = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) mode = 0;
    else if (warm_req) begin mode = 1; j = 0; warm_path = 1'b1; end
    else if (mode == 0) begin
      if (pwr_stable) begin mode = 1; j = 0; warm_path = 1'b0; end
    end else if (j < 1000000) j = j + 1;
  end

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic e_rst, e_cke, e_done;
      logic [3:0] e_cmd;
      logic [2:0] e_ba;
      logic [AW-1:0] e_addr;
      string t_rst, t_cmd, t_addr;
      int hold, base, m0, zq;
      e_rst = 0; e_cke = 0; e_done = 0; e_cmd = 4'b0111; e_ba = 0; e_addr = 0;
      t_rst = cold_tag; t_cmd = "R4"; t_addr = "R4";
      if (mode == 1) begin
        hold  = warm_path ? TW : TC;
        t_rst = warm_path ? "R3" : "R2";
        e_rst = (j >= hold);
        e_cke = (j >= hold + TCKE);
        base  = hold + TCKE + TXPR;
        m0    = base + 3*TMRD;
        zq    = m0 + TMOD;
        if (j == base)          begin e_cmd = 0; e_ba = 3'b010; e_addr = w2 & ~14'h3907; t_cmd = "R6"; t_addr = "R7"; end
        if (j == base + TMRD)   begin e_cmd = 0; e_ba = 3'b011; e_addr = w3 & ~14'h3FF8; t_cmd = "R6"; t_addr = "R7"; end
        if (j == base + 2*TMRD) begin e_cmd = 0; e_ba = 3'b001; e_addr = w1 & ~14'h2501; t_cmd = "R6"; t_addr = "R7"; end
        if (j == m0)            begin e_cmd = 0; e_ba = 3'b000; e_addr = (w0 & ~14'h2084) | 14'h0100; t_cmd = "R6"; t_addr = "R7"; end
        if (j == zq)            begin e_cmd = 4'b0110; e_addr = 14'h0400; t_cmd = "R8"; t_addr = "R8"; end
        e_done = (j >= m0 + ((TMOD + TZQ > TDLLK) ? TMOD + TZQ : TDLLK));
      end
      chk(t_rst, "mem_reset_n", 32'(mem_reset_n), 32'(e_rst));
      chk("R5",  "mem_cke",     32'(mem_cke),     32'(e_cke));
      chk("R5",  "mem_odt",     32'(mem_odt),     32'(1'b0));
      chk(t_cmd, "cmd",         32'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), 32'(e_cmd));
      chk(t_cmd, "mem_ba",      32'(mem_ba),      32'(e_ba));
      chk(t_addr,"mem_addr",    32'(mem_addr),    32'(e_addr));
      chk((mode == 0) ? cold_tag : "R9", "init_done", 32'(init_done), 32'(e_done));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    w0 = 14'h3FFF; w1 = 14'h3FFF; w2 = 14'h3FFF; w3 = 14'h3FFF;
    step(3);
    rst_n = 1'b1;
    step(8);                              // R1: supply wait holds everything low
    pwr_stable = 1'b1;
    step(120);                            // R2, R5, R6, R7, R8, R9 on cold path
    warm_req = 1'b1; step(1); warm_req = 1'b0;
    step(50);                             // R3: warm restart after ready, mid-way
    warm_req = 1'b1; step(2); warm_req = 1'b0;
    step(115);                            // R3: held request, full warm run
    step(30);
    cold_tag = "R10";
    rst_n = 1'b0; pwr_stable = 1'b0;
    w0 = 14'h2A5A; w1 = 14'h15A5; w2 = 14'h0F0F; w3 = 14'h0007;
    step(2);
    rst_n = 1'b1;
    step(5);                              // R10: back on cold path waiting
    pwr_stable = 1'b1;
    step(120);
    cold_tag = "R1";
    rst_n = 1'b0; pwr_stable = 1'b0;
    w0 = 14'h0000; w1 = 14'h0001; w2 = 14'h0038; w3 = 14'h0004;
    step(2);
    rst_n = 1'b1;
    step(3);
    warm_req = 1'b1; step(1); warm_req = 1'b0;   // R3: warm path without pwr_stable
    step(115);
    report();
  end

endmodule